// File: doc/BRIEF.md
# Phase-Error Window Unlock Detector

This block decides whether a frequency-synthesizer loop has fallen out of lock. It watches the phase-error pulse coming from the phase comparator. It measures how long each pulse stays high by counting cycles of a reference clock. When a pulse lasts longer than a selected window, the block reports the loop as unlocked. The phase-error input is taken to be synchronous to that reference clock.

A 2-bit select chooses one of four behaviours. One code turns the detector off. One code copies the raw phase-error pulse straight to the output, which acts as a zero-width window. The two remaining codes both apply a window of `WIN_CYC` reference cycles, which is about 6.67 µs at the intended clock rate. In these two codes, each violation arms a retriggerable hold timer. That timer counts coarse ticks from an internal prescaler, so the indication lasts between one and two milliseconds after the last violation.

There are two outputs. The first is an active-high unlock indicator, which feeds an output-pin selector. The second is a status bit for the serial read-back path, which reads 0 while unlock is flagged.

Top module: `pll_unlock_detect`

## Requirements
- R1: With select code 00 the detector is off: `unlock_o` is 0 and `lock_bit_o` is 1 whatever `phase_err_i` does.
- R2: With select code 01, `unlock_o` equals `phase_err_i` in the same cycle, with no register in the path.
- R3: With select code 10 or 11, a phase-error pulse of at most `WIN_CYC` consecutive high cycles never raises `unlock_o`.
- R4: With select code 10 or 11, a pulse longer than `WIN_CYC` cycles raises `unlock_o`. Counting the pulse's first high cycle as cycle 0, `unlock_o` is first high in cycle `WIN_CYC+1`.
- R5: After the last high cycle beyond the window, `unlock_o` stays high for at least `HOLD_TICKS*TICK_DIV+1` cycles and at most `(HOLD_TICKS+1)*TICK_DIV` cycles. The count starts with the first cycle after the pulse ends.
- R6: The hold is retriggerable. A new violation during a running hold restarts the hold from that violation.
- R7: Whenever the select is not 00, `lock_bit_o` is the inverse of `unlock_o`.
- R8: After reset, `unlock_o` is 0 and `lock_bit_o` is 1.
- R9: Leaving codes 10/11 drops a running hold at once. It does not reappear when the select returns to 10 or 11.
- R10: Codes 10 and 11 behave identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock used to time pulse widths |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| win_sel_i | input | 2 | Window select: 00 off, 01 pass-through, 10/11 timed window |
| phase_err_i | input | 1 | Phase-error pulse from the comparator, synchronous to clk_i |
| unlock_o | output | 1 | Unlock indicator, held in window modes |
| lock_bit_o | output | 1 | Status bit for serial read-back, 0 when unlocked |

## Verification
In pass-through mode `unlock_o` is combinational, so the bench samples it in the same cycle it drives `phase_err_i`. In window modes the violation is registered once, so `unlock_o` is due one cycle after the first high cycle beyond `WIN_CYC`. The bench drives inputs just after the falling edge and samples one time unit later. Each sample therefore shows the registers as they stand after the preceding rising edge, together with the current input. The hold length depends on the phase of the free-running prescaler. For that reason the bench counts the high cycles after each pulse and checks the count against the R5 range, rather than expecting a single exact cycle.

// File: rtl/uld_pkg.sv
package uld_pkg;

  typedef enum logic [1:0] {
    ULD_OFF   = 2'b00,
    ULD_PASS  = 2'b01,
    ULD_WIN_A = 2'b10,
    ULD_WIN_B = 2'b11
  } uld_mode_e;

  function automatic logic mode_is_window(input logic [1:0] sel);
    return sel[1];
  endfunction

endpackage

// File: rtl/uld_width_meter.sv
module uld_width_meter #(
  parameter int unsigned WIN_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  output logic over_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  // over_o marks every high cycle that lies beyond the window
  assign over_o = en_i && pulse_i && (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || !pulse_i) begin
      cnt_d = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: the high-cycle count saturates at the window limit
  a_r3_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // R4: a violation needs the previous cycle to have been high as well
  a_r4_over_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && WIN_CYC > 0) |-> $past(pulse_i));

endmodule

// File: rtl/uld_tick_gen.sv
module uld_tick_gen #(
  parameter int unsigned TICK_DIV = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick_o = (pre_q == LAST);

  always_comb begin
    if (tick_o) pre_d = '0;
    else        pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  generate
    if (TICK_DIV > 1) begin : g_tick_check
      // R5: ticks are isolated strobes, never two in a row
      a_r5_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/uld_hold_timer.sv
module uld_hold_timer #(
  parameter int unsigned HOLD_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 2);
  localparam logic [HW-1:0] RELOAD = HW'(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q, hold_d;

  assign active_o = (hold_q != '0);

  always_comb begin
    hold_d = hold_q;
    if (clr_i) begin
      hold_d = '0;
    end else if (load_i) begin
      hold_d = RELOAD;
    end else if (tick_i && active_o) begin
      hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  // R5: the hold count never exceeds its reload value
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= RELOAD);

  // R6: a violation restarts the hold at full length
  a_r6_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (hold_q == RELOAD));

  // R9: clearing empties the hold on the next cycle
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !active_o);

endmodule

// File: rtl/pll_unlock_detect.sv
module pll_unlock_detect
  import uld_pkg::*;
#(
  parameter int unsigned WIN_CYC    = 20,
  parameter int unsigned TICK_DIV   = 3000,
  parameter int unsigned HOLD_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] win_sel_i,
  input  logic       phase_err_i,
  output logic       unlock_o,
  output logic       lock_bit_o
);
  uld_mode_e mode;
  logic      win_en;
  logic      over;
  logic      tick;
  logic      hold_active;

  assign mode   = uld_mode_e'(win_sel_i);
  assign win_en = mode_is_window(win_sel_i);

  uld_width_meter #(.WIN_CYC(WIN_CYC)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (win_en),
    .pulse_i (phase_err_i),
    .over_o  (over)
  );

  uld_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  uld_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!win_en),
    .load_i   (over),
    .tick_i   (tick),
    .active_o (hold_active)
  );

  always_comb begin
    unique case (mode)
      ULD_OFF:   unlock_o = 1'b0;
      ULD_PASS:  unlock_o = phase_err_i;
      default:   unlock_o = hold_active;
    endcase
  end

  assign lock_bit_o = !unlock_o;

  // R1: a stopped detector reports lock
  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_sel_i == 2'b00) |-> (!unlock_o && lock_bit_o));

  // R4: in window modes a fresh unlock follows a high phase-error cycle
  a_r4_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_sel_i[1] && $past(win_sel_i[1]) && $rose(unlock_o)) |-> $past(phase_err_i));

  // R9: re-entering a window mode starts with no stale hold
  a_r9_fresh_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_sel_i[1] && !$past(win_sel_i[1])) |-> !unlock_o);

endmodule

// File: tb/pll_unlock_detect_bench.sv
module pll_unlock_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 8;
  localparam int DIV  = 20;
  localparam int HOLD = 1;

  logic       clk;
  logic       rst_n;
  logic [1:0] sel;
  logic       pe;
  logic       unlock;
  logic       lock_bit;

  int n_checks = 0;
  int n_fail   = 0;

  pll_unlock_detect #(.WIN_CYC(WIN), .TICK_DIV(DIV), .HOLD_TICKS(HOLD)) u_pll_unlock_detect (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .win_sel_i   (sel),
    .phase_err_i (pe),
    .unlock_o    (unlock),
    .lock_bit_o  (lock_bit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk);
    pe = v;
    #1;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  // Counts unlock-high cycles after a pulse has ended
  task automatic hold_len(output int len);
    len = 0;
    for (int i = 0; i < (HOLD+1)*DIV + 10; i++) begin
      step(1'b0);
      if (unlock) len++;
      else break;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sel = 2'b10; pe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 unlock in reset", unlock, 0);
    check("R8 lock_bit in reset", lock_bit, 1);
    @(negedge clk); rst_n = 1'b1;
    quiet(2);
    check("R8 unlock after release", unlock, 0);
  endtask

  task automatic t_off;
    int bad = 0;
    sel = 2'b00;
    for (int i = 0; i < 3*WIN; i++) begin
      step(1'b1);
      if (unlock || !lock_bit) bad++;
    end
    quiet(3);
    check("R1 off mode stays locked", bad, 0);
    check("R1 lock_bit off", lock_bit, 1);
  endtask

  task automatic t_pass;
    sel = 2'b01;
    step(1'b1);
    check("R2 pass high", unlock, 1);
    check("R7 lock_bit pass high", lock_bit, 0);
    step(1'b0);
    check("R2 pass low", unlock, 0);
    check("R7 lock_bit pass low", lock_bit, 1);
    step(1'b1);
    check("R2 pass single", unlock, 1);
    step(1'b0);
  endtask

  task automatic t_within(input logic [1:0] s);
    int seen = 0;
    sel = s;
    quiet(2);
    for (int p = 1; p <= WIN; p += WIN - 1) begin
      for (int i = 0; i < p; i++) begin
        step(1'b1);
        if (unlock) seen++;
      end
      for (int i = 0; i < 3; i++) begin
        step(1'b0);
        if (unlock) seen++;
      end
    end
    check("R3 window-length pulses no unlock", seen, 0);
  endtask

  task automatic t_exceed(input logic [1:0] s, input string tag);
    int first = -1;
    int len;
    sel = s;
    quiet(2);
    for (int i = 0; i <= WIN; i++) begin
      step(1'b1);
      if (unlock && first < 0) first = i;
    end
    step(1'b0);
    if (unlock && first < 0) first = WIN + 1;
    check({tag, " R4 unlock first cycle"}, first, WIN + 1);
    check({tag, " R7 lock_bit inverse"}, lock_bit, 0);
    hold_len(len);
    len = len + 1;
    check({tag, " R5 hold not short"}, int'(len >= HOLD*DIV + 1), 1);
    check({tag, " R5 hold not long"}, int'(len <= (HOLD+1)*DIV), 1);
    check({tag, " R5 released"}, unlock, 0);
  endtask

  task automatic t_retrigger;
    int len;
    sel = 2'b10;
    quiet(2);
    for (int i = 0; i <= WIN; i++) step(1'b1);
    quiet(DIV/2);
    for (int i = 0; i <= WIN + 1; i++) step(1'b1);
    hold_len(len);
    check("R6 retriggered hold not short", int'(len >= HOLD*DIV + 1), 1);
    check("R6 retriggered hold not long", int'(len <= (HOLD+1)*DIV), 1);
  endtask

  task automatic t_leave;
    sel = 2'b10;
    quiet(2);
    for (int i = 0; i <= WIN; i++) step(1'b1);
    step(1'b0);
    check("R9 hold running", unlock, 1);
    sel = 2'b00;
    step(1'b0);
    check("R9 dropped on leaving", unlock, 0);
    quiet(1);
    sel = 2'b10;
    step(1'b0);
    check("R9 no stale hold on return", unlock, 0);
    quiet(2);
    check("R9 still clear", unlock, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_off();
    t_pass();
    t_within(2'b10);
    t_within(2'b11);
    t_exceed(2'b10, "code10");
    t_exceed(2'b11, "code11 R10");
    t_retrigger();
    t_leave();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule